// File: doc/BRIEF.md
# Query Error Detector and Register

This block watches the message-exchange state of a programmable instrument's command interface and flags the three query protocol errors: a talk request that has no response to give (unterminated), a pending response that new input has overtaken (interrupted), and a pending response that is blocked by a full input queue (deadlock). It takes level flags from the listener, the parser and the response formatter, and a count of END messages that are waiting in the input queue.

When it detects an error, the block raises a one-cycle query-error event for the standard event status logic. It loads the error's code into a readable register and pulses the recovery reset for that error. An unterminated error resets the parser. An interrupted or deadlock error resets the response formatter, which empties the output queue, and parsing then continues with the next queued unit. When several conditions hold in the same cycle, a fixed priority chooses one of them.

Top module: `qerr_unit`

## Requirements
- R1: While reset is asserted and after it is released, `qerr_evt_o`, `parser_rst_o` and `fmt_rst_o` are 0 and `qerr_code_o` reads 0 (no error).
- R2: The unterminated error is raised when `talk_addr_i`=1, `fmt_active_i`=0 and `inq_empty_i`=1. One cycle later it gives `qerr_evt_o`=1, `parser_rst_o`=1, `fmt_rst_o`=0 and code 3.
- R3: With `fmt_wait_i`=1, a `term_seen_i` pulse raises the interrupted error. One cycle later it gives `qerr_evt_o`=1, `fmt_rst_o`=1, `parser_rst_o`=0 and code 1.
- R4: With `fmt_wait_i`=1, an `end_cnt_i` value of 2 or more also raises the interrupted error (code 1, formatter reset). A count of 0 or 1 with no terminator raises no error.
- R5: With `fmt_wait_i`=1, a 0-to-1 transition of `inq_full_i` raises the deadlock error. One cycle later it gives `qerr_evt_o`=1, `fmt_rst_o`=1, `parser_rst_o`=0 and code 2.
- R6: When `inq_full_i` stays at 1, it produces at most one deadlock error. A queue that became full while `fmt_wait_i`=0 produces no deadlock error.
- R7: When several conditions hold in the same cycle, deadlock wins over interrupted, and interrupted wins over unterminated. Only the winner's code and reset are output.
- R8: `qerr_code_o` keeps the latest error code until the next error or until `clr_i`=1, which sets it to 0 one cycle later. If an error and a clear fall in the same cycle, the error's code is loaded.
- R9: `qerr_evt_o`, `parser_rst_o` and `fmt_rst_o` are 1 only in the cycle that follows a cycle with a detected condition. The two reset outputs are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| talk_addr_i | input | 1 | Device is addressed to talk |
| fmt_active_i | input | 1 | Response formatter is busy (not idle) |
| fmt_wait_i | input | 1 | Response formatter is holding a response ready to send |
| inq_empty_i | input | 1 | Input queue is empty |
| inq_full_i | input | 1 | Input queue is full |
| end_cnt_i | input | CNT_W | Number of END messages held in the input queue |
| term_seen_i | input | 1 | Parser has read a program message terminator (pulse) |
| clr_i | input | 1 | Synchronous clear of the error code register |
| qerr_evt_o | output | 1 | One-cycle query-error event for the event status register |
| qerr_code_o | output | 2 | Code of the latest query error (0 none, 1 interrupted, 2 deadlock, 3 unterminated) |
| parser_rst_o | output | 1 | One-cycle parser reset |
| fmt_rst_o | output | 1 | One-cycle response formatter reset, which clears the output queue |

## Verification
Each result is due exactly one clock edge after the inputs that cause it. The event, both resets and the code all come from the same rank of registers. The deadlock case depends on the full flag from the cycle before, so it needs one extra cycle of history. The bench drives a new input set at each falling edge and computes the expected outputs for that set, including its own copy of the previous full flag. It compares them at the next falling edge, after exactly one rising edge. Directed cases cover a queue that stays full, overlapping conditions, an END count at the boundary, and a clear that meets an error in the same cycle.

// File: rtl/qerr_pkg.sv
package qerr_pkg;
  typedef enum logic [1:0] {
    QE_NONE   = 2'd0,
    QE_INTR   = 2'd1,
    QE_DLOCK  = 2'd2,
    QE_UNTERM = 2'd3
  } qerr_code_e;

  typedef struct packed {
    logic dlock;
    logic intr;
    logic unterm;
  } qerr_hits_t;
endpackage

// File: rtl/qerr_cond.sv
module qerr_cond
  import qerr_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             talk_addr_i,
  input  logic             fmt_active_i,
  input  logic             fmt_wait_i,
  input  logic             inq_empty_i,
  input  logic             inq_full_i,
  input  logic [CNT_W-1:0] end_cnt_i,
  input  logic             term_seen_i,
  output qerr_hits_t       hits_o,
  output logic             full_rise_o
);
  localparam logic [CNT_W-1:0] END_LIM = CNT_W'(1);

  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= inq_full_i;
  end

  assign full_rise_o = inq_full_i & ~full_q;

  always_comb begin
    hits_o.dlock  = fmt_wait_i & full_rise_o;
    hits_o.intr   = fmt_wait_i & (term_seen_i | (end_cnt_i > END_LIM));
    hits_o.unterm = talk_addr_i & ~fmt_active_i & inq_empty_i;
  end
endmodule

// File: rtl/qerr_arb.sv
module qerr_arb
  import qerr_pkg::*;
(
  input  qerr_hits_t hits_i,
  output logic       hit_o,
  output qerr_code_e code_o,
  output logic       prst_o,
  output logic       frst_o
);
  always_comb begin
    code_o = QE_NONE;
    prst_o = 1'b0;
    frst_o = 1'b0;
    // fixed priority: deadlock > interrupted > unterminated
    if (hits_i.dlock) begin
      code_o = QE_DLOCK;
      frst_o = 1'b1;
    end else if (hits_i.intr) begin
      code_o = QE_INTR;
      frst_o = 1'b1;
    end else if (hits_i.unterm) begin
      code_o = QE_UNTERM;
      prst_o = 1'b1;
    end
    hit_o = prst_o | frst_o;
  end
endmodule

// File: rtl/qerr_unit.sv
module qerr_unit
  import qerr_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             talk_addr_i,
  input  logic             fmt_active_i,
  input  logic             fmt_wait_i,
  input  logic             inq_empty_i,
  input  logic             inq_full_i,
  input  logic [CNT_W-1:0] end_cnt_i,
  input  logic             term_seen_i,
  input  logic             clr_i,
  output logic             qerr_evt_o,
  output logic [1:0]       qerr_code_o,
  output logic             parser_rst_o,
  output logic             fmt_rst_o
);
  qerr_hits_t hits;
  logic       full_rise;
  logic       hit, prst, frst;
  qerr_code_e code_d;
  qerr_code_e code_q;

  qerr_cond #(.CNT_W(CNT_W)) u_cond (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .talk_addr_i (talk_addr_i),
    .fmt_active_i(fmt_active_i),
    .fmt_wait_i  (fmt_wait_i),
    .inq_empty_i (inq_empty_i),
    .inq_full_i  (inq_full_i),
    .end_cnt_i   (end_cnt_i),
    .term_seen_i (term_seen_i),
    .hits_o      (hits),
    .full_rise_o (full_rise)
  );

  qerr_arb u_arb (
    .hits_i(hits),
    .hit_o (hit),
    .code_o(code_d),
    .prst_o(prst),
    .frst_o(frst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q       <= QE_NONE;
      qerr_evt_o   <= 1'b0;
      parser_rst_o <= 1'b0;
      fmt_rst_o    <= 1'b0;
    end else begin
      qerr_evt_o   <= hit;
      parser_rst_o <= prst;
      fmt_rst_o    <= frst;
      // a new error outranks a clear in the same cycle
      if (hit)        code_q <= code_d;
      else if (clr_i) code_q <= QE_NONE;
    end
  end

  assign qerr_code_o = code_q;

  // R2
  unterm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    talk_addr_i && !fmt_active_i && inq_empty_i && !fmt_wait_i
    |=> parser_rst_o && !fmt_rst_o && qerr_code_o == 2'd3);

  // R3
  intr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_wait_i && term_seen_i && !full_rise
    |=> fmt_rst_o && qerr_code_o == 2'd1);

  // R5
  dlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_wait_i && full_rise |=> fmt_rst_o && qerr_code_o == 2'd2);

  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inq_full_i && !full_rise && !term_seen_i && end_cnt_i <= CNT_W'(1)
    && !(talk_addr_i && !fmt_active_i && inq_empty_i)
    |=> !qerr_evt_o);

  // R8
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit && !clr_i |=> $stable(qerr_code_o));

  // R9
  rst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(parser_rst_o && fmt_rst_o));

  // R9
  evt_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qerr_evt_o |-> qerr_code_o != 2'd0);
endmodule

// File: tb/qerr_unit_tb_top.sv
`timescale 1ns/1ps
module qerr_unit_tb_top;
  localparam int unsigned CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic talk, act, wt, emp, full, ts, clr;
  logic [CNT_W-1:0] ecnt;
  logic evt, prst, frst;
  logic [1:0] code;

  int total = 0;
  int bad = 0;
  bit m_full = 1'b0;
  logic [1:0] m_code = 2'd0;
  bit e_evt, e_prst, e_frst;
  string e_req;

  always #5 clk = ~clk;

  qerr_unit #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .talk_addr_i(talk), .fmt_active_i(act), .fmt_wait_i(wt),
    .inq_empty_i(emp), .inq_full_i(full), .end_cnt_i(ecnt),
    .term_seen_i(ts), .clr_i(clr),
    .qerr_evt_o(evt), .qerr_code_o(code),
    .parser_rst_o(prst), .fmt_rst_o(frst)
  );

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // expected result of one input set, per requirements
  function automatic logic [1:0] exp_sel(bit t, bit a, bit w, bit e, bit f, int n,
                                        bit s, bit pf);
    bit dl, it, un;
    dl = w && f && !pf;
    it = w && (s || n > 1);
    un = t && !a && e;
    if (dl) return 2'd2;
    if (it) return 2'd1;
    if (un) return 2'd3;
    return 2'd0;
  endfunction

  task automatic step(bit t, bit a, bit w, bit e, bit f, int n, bit s, bit c,
                      string tag);
    logic [1:0] sel;
    talk = t; act = a; wt = w; emp = e; full = f;
    ecnt = CNT_W'(n); ts = s; clr = c;
    sel = exp_sel(t, a, w, e, f, n, s, m_full);
    m_full = f;
    e_evt  = sel != 2'd0;
    e_prst = sel == 2'd3;
    e_frst = sel == 2'd1 || sel == 2'd2;
    if (e_evt) m_code = sel;
    else if (c) m_code = 2'd0;
    if (tag != "") e_req = tag;
    else if (sel == 2'd2) e_req = "R5";
    else if (sel == 2'd1) e_req = s ? "R3" : "R4";
    else if (sel == 2'd3) e_req = "R2";
    else e_req = "R9";
    @(negedge clk);
    chk(e_req, 32'(evt), 32'(e_evt));
    chk(e_req, 32'(prst), 32'(e_prst));
    chk(e_req, 32'(frst), 32'(e_frst));
    chk((c && !e_evt) ? "R8" : e_req, 32'(code), 32'(m_code));
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    talk = 0; act = 0; wt = 0; emp = 0; full = 0; ecnt = '0; ts = 0; clr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 32'(evt), 0); chk("R1", 32'(prst), 0);
    chk("R1", 32'(frst), 0); chk("R1", 32'(code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(code), 0); chk("R1", 32'(evt), 0);

    // R2 unterminated
    step(1, 0, 0, 1, 0, 0, 0, 0, "R2");
    // R8 code holds while quiet
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R3 terminator while waiting
    step(0, 1, 1, 0, 0, 0, 1, 0, "R3");
    // R4 boundary: one END, no error; two ENDs, error
    step(0, 1, 1, 0, 0, 1, 0, 0, "R4");
    step(0, 1, 1, 0, 0, 2, 0, 0, "R4");
    // R5 / R6 deadlock then persistent full
    step(0, 1, 1, 0, 1, 0, 0, 0, "R5");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R6");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R6");
    // R6 full arrives before waiting: no deadlock
    step(0, 1, 0, 0, 1, 0, 0, 0, "R6");
    step(0, 1, 1, 0, 1, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R6");
    // R7 all three together -> deadlock
    step(1, 0, 1, 1, 1, 3, 1, 0, "R7");
    // R7 interrupted over unterminated
    step(1, 0, 1, 1, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R8 clear, then clear colliding with error
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
    step(1, 0, 0, 1, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 5) < 2, int'($urandom % 4),
           ($urandom % 8) == 0, ($urandom % 10) == 0, "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule